// File: doc/BRIEF.md
# SPI Slave with Padded Command Reply

This block is an SPI slave that sits on a chip-select framed bus and talks to logic in its own system clock domain. Every byte the master shifts in is handed to the system side on a small receive port. Every byte slot the slave shifts out is taken from a transmit queue that the system side fills. When the queue is empty, a fill byte goes out instead. The clock phase and polarity are fixed by parameters, and bits travel most significant first in both directions.

One command code gets special handling in hardware. When that byte arrives, any stale bytes still queued are thrown away and the reply code is queued at once. A parameter can place a fixed number of pad slots ahead of the reply. The master knows how many there are and skips them. System logic that needs more than one byte slot to prepare extra reply bytes can push them during the pad slots, and they follow the reply code.

The bus pins are sampled through synchronizers in the system clock. SCLK must therefore stay in each level for at least SYNC_STAGES + 4 system clock cycles.

Top module: `spi_resp_slave`

## Requirements
- R1: Each byte the master sends is captured MSB first. The capture edge is the leading SCLK edge when CPHA=0 and the trailing edge when CPHA=1; CPOL sets the idle level. After the eighth capture edge the byte appears on rx_data with rx_valid high.
- R2: MISO carries bytes MSB first. Bytes pushed on rsp_push/rsp_data go out in push order, one per byte slot. Each bit is stable before the edge on which the master captures it.
- R3: When the transmit queue is empty and no pad slots are owed, a slot carries FILL_BYTE (default 0x00).
- R4: When a received byte equals CMD_CODE (default 0x01), every queued byte is discarded and RSP_CODE (default 0x02) becomes the only queued byte.
- R5: After a command, the next PAD_COUNT slots carry PAD_BYTE. RSP_CODE follows, then any bytes pushed after the command, in push order.
- R6: With PAD_COUNT=0, RSP_CODE goes out in the byte slot right after the command, in the same frame.
- R7: While spi_cs_n is high, spi_miso_oe is low; it is also low after reset. Raising spi_cs_n drops a partly received byte without raising rx_valid, and the next frame starts counting bits afresh.
- R8: If a byte completes while rx_valid is still set and rx_take is low, rx_overrun goes high and rx_data holds the newer byte. A later rx_take clears rx_valid and rx_overrun.
- R9: A queued byte is used up only when its slot receives its first clock edge. A byte staged at the end of a frame but never clocked goes out in the next frame.
- R10: A received byte other than CMD_CODE leaves the transmit queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select framing a transfer |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for MISO; low means high impedance |
| rx_valid | output | 1 | A received byte is waiting on rx_data |
| rx_data | output | DW | Last received byte |
| rx_take | input | 1 | Consumes the waiting received byte |
| rx_overrun | output | 1 | A byte arrived before the previous one was taken |
| rsp_push | input | 1 | Queues rsp_data for transmission |
| rsp_data | input | DW | Byte to queue |

## Verification
The bench builds two copies of the block. The first uses CPOL=0, CPHA=0 and PAD_COUNT=0. This copy covers the reply in the very next slot, the byte staged when chip select falls, and the deferred use of a byte staged at the end of a frame. The second uses CPOL=1, CPHA=1, PAD_COUNT=2 and a pad byte of 0x5A. It loads on the leading edge and counts pad slots with a value that cannot be mistaken for the fill byte. Both copies receive directed frames for flush, overrun and aborted bytes, followed by seeded random frames in which random host pushes mix with commands.

// File: rtl/spi_resp_pkg.sv
package spi_resp_pkg;
  // Source of the byte staged for the next transmit slot.
  typedef enum logic [1:0] {
    SRC_FILL = 2'd0,
    SRC_PAD  = 2'd1,
    SRC_FIFO = 2'd2
  } src_e;
endpackage

// File: rtl/spi_resp_sync.sv
module spi_resp_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] ff [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) ff[s] <= RST_VAL;
    end else begin
      ff[0] <= d;
      for (int s = 1; s < STAGES; s++) ff[s] <= ff[s-1];
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/spi_resp_fifo.sv
module spi_resp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8   // power of two, at least 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          full, wr_en;
  logic [AW-1:0] waddr;

  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign empty = (wp == rp);
  assign level = wp - rp;
  // A flush with a push restarts the queue holding only the new byte.
  assign wr_en = push && (flush || !full);
  assign waddr = flush ? '0 : wp[AW-1:0];
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      rp <= '0;
      wp <= push ? (AW+1)'(1) : '0;
    end else begin
      if (wr_en)         wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  p_flush_load_r4: assert property (@(posedge clk) disable iff (rst)
    flush && push |=> (level == 1) && (rdata == $past(wdata)));
endmodule

// File: rtl/spi_resp_shift.sv
module spi_resp_shift #(
  parameter int CPOL = 0,
  parameter int CPHA = 0,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          cs_n_s,
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_byte,
  output logic          ld,        // tx_byte is staged into the shifter now
  output logic          commit,    // the staged byte's slot has begun
  output logic          rx_done,
  output logic [DW-1:0] rx_byte,
  output logic          miso,
  output logic          miso_oe
);
  localparam int CW = $clog2(DW);

  logic          sclk_d, act, act_d, rise, fall, lead, trail, smp, shf;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh_in, tx_sh;

  assign act   = ~cs_n_s;
  assign rise  = sclk_s & ~sclk_d;
  assign fall  = ~sclk_s & sclk_d;
  assign lead  = act & ((CPOL != 0) ? fall : rise);
  assign trail = act & ((CPOL != 0) ? rise : fall);

  generate
    if (CPHA == 0) begin : g_ph0
      // Capture on leading edges; the first bit must be out when select falls.
      assign smp    = lead;
      assign shf    = trail;
      assign ld     = act & (~act_d | (shf & (cnt == '0)));
      assign commit = smp & (cnt == '0);
    end else begin : g_ph1
      assign smp    = trail;
      assign shf    = lead;
      assign ld     = shf & (cnt == '0);
      assign commit = ld;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= (CPOL != 0);
      act_d   <= 1'b0;
      cnt     <= '0;
      sh_in   <= '0;
      tx_sh   <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      rx_done <= 1'b0;
      rx_byte <= '0;
    end else begin
      sclk_d  <= sclk_s;
      act_d   <= act;
      miso_oe <= act;
      rx_done <= 1'b0;
      if (!act) begin
        cnt <= '0;
      end else begin
        if (smp) begin
          sh_in <= {sh_in[DW-2:0], mosi_s};
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(DW-1)) begin
            rx_done <= 1'b1;
            rx_byte <= {sh_in[DW-2:0], mosi_s};
          end
        end
        if (ld) begin
          miso  <= tx_byte[DW-1];
          tx_sh <= {tx_byte[DW-2:0], 1'b0};
        end else if (shf) begin
          miso  <= tx_sh[DW-1];
          tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  p_byte_done_r1: assert property (@(posedge clk) disable iff (rst)
    smp && (cnt == CW'(DW-1)) |=> rx_done);
  p_miso_hold_r2: assert property (@(posedge clk) disable iff (rst)
    act && !shf && !ld |=> $stable(miso));
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !act |=> !miso_oe && (cnt == '0) && !rx_done);
endmodule

// File: rtl/spi_resp_slave.sv
module spi_resp_slave
  import spi_resp_pkg::*;
#(
  parameter int          CPOL        = 0,
  parameter int          CPHA        = 0,
  parameter int          DW          = 8,
  parameter int          FIFO_DEPTH  = 8,
  parameter int          PAD_COUNT   = 0,
  parameter logic [DW-1:0] PAD_BYTE  = '0,
  parameter logic [DW-1:0] FILL_BYTE = '0,
  parameter logic [DW-1:0] CMD_CODE  = DW'(8'h01),
  parameter logic [DW-1:0] RSP_CODE  = DW'(8'h02),
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_take,
  output logic          rx_overrun,
  input  logic          rsp_push,
  input  logic [DW-1:0] rsp_data
);
  localparam int         PW       = $clog2(PAD_COUNT + 2);
  localparam int         LW       = $clog2(FIFO_DEPTH) + 1;
  localparam logic [2:0] SYNC_RST = {(CPOL != 0), 1'b1, 1'b0};

  logic          sclk_s, cs_n_s, mosi_s;
  logic          ld, commit, rx_done_i, cmd_hit;
  logic [DW-1:0] rx_byte_i, tx_byte, fifo_rdata;
  logic          fifo_empty, fifo_pop;
  logic [LW-1:0] fifo_level;
  logic [PW-1:0] pad_left;
  src_e          src_now, staged, commit_src;

  spi_resp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q({sclk_s, cs_n_s, mosi_s})
  );

  spi_resp_shift #(.CPOL(CPOL), .CPHA(CPHA), .DW(DW)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .tx_byte(tx_byte), .ld(ld), .commit(commit), .rx_done(rx_done_i),
    .rx_byte(rx_byte_i), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  assign cmd_hit = rx_done_i && (rx_byte_i == CMD_CODE);

  spi_resp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .flush(cmd_hit),
    .push(cmd_hit | rsp_push),
    .wdata(cmd_hit ? RSP_CODE : rsp_data),
    .pop(fifo_pop), .rdata(fifo_rdata), .empty(fifo_empty), .level(fifo_level)
  );

  // Byte offered to the shifter: owed pads first, then the queue, then fill.
  always_comb begin
    if (pad_left != '0)   src_now = SRC_PAD;
    else if (!fifo_empty) src_now = SRC_FIFO;
    else                  src_now = SRC_FILL;
    case (src_now)
      SRC_PAD:  tx_byte = PAD_BYTE;
      SRC_FIFO: tx_byte = fifo_rdata;
      default:  tx_byte = FILL_BYTE;
    endcase
  end

  // A staged byte is only used up once its slot sees its first edge.
  assign commit_src = ld ? src_now : staged;
  assign fifo_pop   = commit && (commit_src == SRC_FIFO) && !cmd_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged   <= SRC_FILL;
      pad_left <= '0;
    end else begin
      if (ld) staged <= src_now;
      if (cmd_hit)
        pad_left <= PW'(PAD_COUNT);
      else if (commit && (commit_src == SRC_PAD) && (pad_left != '0))
        pad_left <= pad_left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_overrun <= 1'b0;
    end else if (rx_done_i) begin
      rx_data  <= rx_byte_i;
      rx_valid <= 1'b1;
      if (rx_valid && !rx_take) rx_overrun <= 1'b1;
    end else if (rx_take) begin
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end
  end

  p_reply_queued_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_hit |=> (fifo_level == LW'(1)) && (pad_left == PW'(PAD_COUNT)));
  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    rx_done_i && rx_valid && !rx_take |=> rx_overrun && rx_valid);
  p_take_r8: assert property (@(posedge clk) disable iff (rst)
    rx_take && !rx_done_i |=> !rx_valid && !rx_overrun);
endmodule

// File: tb/spi_resp_slave_harness.sv
module spi_resp_slave_harness #(
  parameter int         CPOL = 0,
  parameter int         CPHA = 0,
  parameter int         PAD  = 0,
  parameter logic [7:0] PADB = 8'h00,
  parameter int         SEED = 1
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   n_chk,
  output int   n_err
);
  localparam int H     = 8;
  localparam int DEPTH = 8;

  logic       sclk, cs_n, mosi, rx_take, rsp_push;
  logic [7:0] rsp_data, rx_data;
  logic       miso, miso_oe, rx_valid, rx_overrun;

  spi_resp_slave #(.CPOL(CPOL), .CPHA(CPHA), .FIFO_DEPTH(DEPTH),
                   .PAD_COUNT(PAD), .PAD_BYTE(PADB)) u_spi_resp_slave (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_take(rx_take), .rx_overrun(rx_overrun),
    .rsp_push(rsp_push), .rsp_data(rsp_data)
  );

  logic [7:0] mq[$];
  int         padm;
  bit         after_cmd;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (cpol=%0d cpha=%0d) actual=%h expected=%h",
               tag, CPOL, CPHA, act, exp);
    end
  endtask

  task automatic next_out(output logic [7:0] b, output string tag);
    if (padm > 0) begin
      padm--; b = PADB; tag = "R5 pad slot";
    end else if (mq.size() > 0) begin
      b = mq.pop_front();
      tag = (after_cmd && PAD == 0) ? "R6 reply next slot" : "R2 queued byte";
    end else begin
      b = 8'h00; tag = "R3 fill byte";
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    if (CPHA == 0) begin
      mosi = tx[7];
      for (int i = 0; i < n; i++) begin
        wait_h(); sclk = ~CPOL[0]; rx = {rx[6:0], miso};
        wait_h(); sclk = CPOL[0];
        if (i < 7) mosi = tx[6-i];
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        sclk = ~CPOL[0]; mosi = tx[7-i];
        wait_h(); sclk = CPOL[0]; rx = {rx[6:0], miso};
        wait_h();
      end
    end
  endtask

  task automatic frame_begin();
    cs_n = 1'b0; wait_h();
  endtask

  task automatic frame_end();
    wait_h(); cs_n = 1'b1; wait_h(); wait_h();
  endtask

  task automatic take_pulse();
    rx_take = 1'b1; @(negedge clk); rx_take = 1'b0; @(negedge clk);
  endtask

  task automatic slot(input logic [7:0] tx, input bit take, output logic [7:0] r);
    logic [7:0] e;
    string      tag;
    next_out(e, tag);
    xfer_bits(tx, 8, r);
    chk(r === e, tag, r, e);
    chk(rx_valid === 1'b1 && rx_data === tx, "R1 received byte", rx_data, tx);
    after_cmd = 1'b0;
    if (tx == 8'h01) begin
      mq.delete(); mq.push_back(8'h02); padm = PAD; after_cmd = 1'b1;
    end
    if (take) take_pulse();
  endtask

  task automatic push(input logic [7:0] b);
    rsp_push = 1'b1; rsp_data = b; @(negedge clk);
    rsp_push = 1'b0; @(negedge clk);
    if (mq.size() < DEPTH) mq.push_back(b);
  endtask

  initial begin
    logic [7:0] r;
    logic [7:0] e;
    string      t;
    sclk = CPOL[0]; cs_n = 1'b1; mosi = 1'b0; rx_take = 1'b0;
    rsp_push = 1'b0; rsp_data = '0; done = 1'b0; n_chk = 0; n_err = 0;
    padm = 0; after_cmd = 1'b0;
    void'($urandom(SEED));
    @(negedge clk);
    while (rst) @(negedge clk);
    repeat (4) @(negedge clk);

    // Reset state
    chk(miso_oe === 1'b0, "R7 reset drive enable", {7'b0, miso_oe}, 8'h00);
    chk(rx_valid === 1'b0, "R8 reset rx_valid", {7'b0, rx_valid}, 8'h00);
    chk(rx_overrun === 1'b0, "R8 reset overrun", {7'b0, rx_overrun}, 8'h00);

    // Empty queue: fill bytes
    frame_begin(); slot(8'h33, 1, r); slot(8'h44, 1, r); frame_end();

    // Command then padding and reply
    frame_begin(); slot(8'h01, 1, r);
    for (int k = 0; k < PAD + 2; k++) slot(8'h00, 1, r);
    frame_end();

    // Stale bytes flushed by a command
    push(8'h11); push(8'h22); push(8'h33);
    frame_begin(); slot(8'h01, 1, r);
    for (int k = 0; k < PAD + 1; k++) slot(8'h00, 1, r);
    slot(8'h00, 1, r);
    chk(r === 8'h00, "R4 stale bytes discarded", r, 8'h00);
    frame_end();

    // Bytes pushed after a command follow the reply
    frame_begin(); slot(8'h01, 1, r); frame_end();
    push(8'hA1); push(8'hA2);
    frame_begin();
    for (int k = 0; k < PAD + 3; k++) slot(8'h00, 1, r);
    chk(r === 8'hA2, "R5 pushed bytes after reply", r, 8'hA2);
    frame_end();

    // Non-command bytes leave the queue alone
    push(8'h77); push(8'h78);
    frame_begin(); slot(8'h33, 1, r); slot(8'h34, 1, r);
    chk(r === 8'h78, "R10 queue kept", r, 8'h78);
    frame_end();

    // Byte staged at end of frame is not lost
    push(8'h61); push(8'h62);
    frame_begin(); slot(8'h55, 1, r); frame_end();
    frame_begin(); slot(8'h56, 1, r);
    chk(r === 8'h62, "R9 staged byte kept", r, 8'h62);
    frame_end();

    // Aborted byte
    push(8'h71);
    frame_begin();
    next_out(e, t);
    xfer_bits(8'hF0, 3, r);
    chk(miso_oe === 1'b1, "R7 drive enable in frame", {7'b0, miso_oe}, 8'h01);
    cs_n = 1'b1; repeat (6) @(negedge clk);
    chk(miso_oe === 1'b0, "R7 released after select", {7'b0, miso_oe}, 8'h00);
    chk(rx_valid === 1'b0, "R7 partial byte dropped", {7'b0, rx_valid}, 8'h00);
    wait_h();
    frame_begin(); slot(8'h9C, 0, r);
    chk(rx_data === 8'h9C, "R7 bit count restarted", rx_data, 8'h9C);
    take_pulse();
    frame_end();

    // Overrun
    frame_begin(); slot(8'hC1, 0, r); slot(8'hC2, 0, r); frame_end();
    chk(rx_overrun === 1'b1, "R8 overrun raised", {7'b0, rx_overrun}, 8'h01);
    chk(rx_data === 8'hC2, "R8 newer byte kept", rx_data, 8'hC2);
    take_pulse();
    chk(rx_valid === 1'b0 && rx_overrun === 1'b0, "R8 cleared by take",
        {6'b0, rx_valid, rx_overrun}, 8'h00);

    // Random frames
    for (int f = 0; f < 30; f++) begin
      int np;
      int nb;
      np = $urandom_range(0, 3);
      for (int p = 0; p < np; p++) push(8'($urandom));
      nb = $urandom_range(1, 4);
      frame_begin();
      for (int b = 0; b < nb; b++) begin
        logic [7:0] tx;
        tx = ($urandom_range(0, 3) == 0) ? 8'h01 : 8'($urandom);
        slot(tx, 1, r);
      end
      frame_end();
    end
    done = 1'b1;
  end
endmodule

// File: tb/spi_resp_slave_bench.sv
module spi_resp_slave_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done0, done3;
  int   chk0, err0, chk3, err3;

  always #5 clk = ~clk;

  spi_resp_slave_harness #(.CPOL(0), .CPHA(0), .PAD(0), .PADB(8'h00), .SEED(11)) u_h0 (
    .clk(clk), .rst(rst), .done(done0), .n_chk(chk0), .n_err(err0));
  spi_resp_slave_harness #(.CPOL(1), .CPHA(1), .PAD(2), .PADB(8'h5A), .SEED(29)) u_h3 (
    .clk(clk), .rst(rst), .done(done3), .n_chk(chk3), .n_err(err3));

  initial begin
    int cycles;
    int extra;
    extra = 0;
    cycles = 0;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    while (!(done0 === 1'b1 && done3 === 1'b1) && cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(done0 === 1'b1 && done3 === 1'b1)) begin
      extra = 1;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==",
             chk0 + chk3 + extra, err0 + err3 + extra);
    $finish;
  end
endmodule